// File: doc/BRIEF.md
# PCM Serial Frame-Sync Port

This block is the digital side of a telephony voice codec's serial link. Once per frame it sends one companded sample, most significant bit first, on a transmit data pin and receives one sample on a receive data pin. Each direction has its own bit clock and frame-sync input. A system clock at least eight times faster than the fastest bit clock samples all of them, through two-flop synchronizers.

Frame syncs can be short (one bit period) or long (three or more bit periods). The port learns which kind is in use by measuring the transmit frame-sync pulse. In long mode the transmit output window opens at whichever comes later: the sync rising or the bit clock rising. It closes at whichever comes later: the falling bit-clock edge after the eighth bit, or the sync dropping. Outgoing bytes arrive on a valid/ready stream and wait in a one-entry holding buffer until the next frame. Received bytes leave on a valid-only stream with a flag that marks a signalling frame, where the last bit must be decoded as a half step.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the port is in short mode (`long_mode`=0), `tx_pcm_oe`=0, `s_tready`=1 and `m_tvalid`=0.
- R2: When the transmit sync falls, the mode is updated from the number of falling transmit bit-clock edges seen while it was high. A count of 1 selects short mode. A count of 3 or more selects long mode. A count of 2 leaves the mode unchanged.
- R3: Short mode, transmit side. Suppose the transmit sync is high at a falling bit-clock edge. Then the next rising edge raises `tx_pcm_oe` and presents bit 7. The next seven rising edges present bits 6 down to 0. The falling edge after bit 0 drops `tx_pcm_oe`.
- R4: Long mode, transmit start. `tx_pcm_oe` rises with bit 7 at the later of the sync rising edge and the bit-clock rising edge. The next seven rising edges present bits 6 down to 0.
- R5: Long mode, transmit end. `tx_pcm_oe` falls at the later of two events: the falling bit-clock edge after bit 0 was presented, and the transmit sync going low.
- R6: Short mode, receive side. Suppose the receive sync is high at a falling receive bit-clock edge. Then the next eight falling edges capture bits 7 down to 0.
- R7: Long mode, receive side. A rising edge on the receive sync makes the next eight falling receive bit-clock edges capture bits 7 down to 0.
- R8: `m_half_lsb` is 1 with a received byte exactly when that frame's receive sync lasted two falling bit-clock edges. Otherwise it is 0.
- R9: Each received byte is presented on `m_tdata` with `m_tvalid` high for exactly one system clock. There is no back-pressure: the consumer must take it in that cycle.
- R10: A byte is accepted when `s_tvalid` and `s_tready` are both high. `s_tready` is low while an accepted byte waits for its frame. The accepted byte goes out in the next frame that starts after acceptance, including one accepted while a frame is shifting. A frame that starts with no byte waiting repeats the last byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the fastest bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync; also sets the framing mode |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_pcm | input | 1 | Serial receive data |
| tx_pcm | output | 1 | Serial transmit data |
| tx_pcm_oe | output | 1 | Output enable for the three-state transmit pin |
| s_tdata | input | DATA_W (8) | Byte to transmit |
| s_tvalid | input | 1 | Transmit byte valid |
| s_tready | output | 1 | Holding buffer free |
| m_tdata | output | DATA_W (8) | Received byte |
| m_tvalid | output | 1 | One-cycle strobe for `m_tdata` |
| m_half_lsb | output | 1 | Received LSB is a signalling bit, decode as half step |
| long_mode | output | 1 | 1 when long framing is in effect |

## Verification
The main function is tried with sync pulses of one, two, three to six and ten bit periods. These separate the mode rules, the signalling flag and the case where the sync outlasts the eighth bit and keeps the output window open. In long mode, one frame raises the sync while the bit clock is low, so the start must wait for the clock edge; the other frames raise both together. Random byte values on both lines, with randomly skipped loads, check bit order and the repeat-last-byte rule. Directed loads check a full buffer and a load made in the middle of a frame.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_ARMED,
    TX_SHIFT,
    TX_DRAIN
  } tx_state_e;
endpackage

// File: rtl/pcm_sync_edge.sv
module pcm_sync_edge #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= '0;
      prev <= '0;
    end else begin
      stg  <= {stg[STAGES-2:0], din};
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/pcm_fs_len.sv
module pcm_fs_len #(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_lvl,
  input  logic             fs_rise,
  input  logic             fs_fall,
  input  logic             b_fall,
  output logic             len_done,
  output logic [LEN_W-1:0] len_cnt
);
  localparam logic [LEN_W-1:0] SAT = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_cnt <= '0;
    else if (fs_rise) len_cnt <= b_fall ? LEN_W'(1) : '0;
    else if (fs_lvl && b_fall && len_cnt != SAT) len_cnt <= len_cnt + 1'b1;
  end

  assign len_done = fs_fall;

  a_r2_len_cleared_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fs_rise) && !$past(b_fall) |-> len_cnt == '0);
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
  import pcm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_mode,
  input  logic              b_lvl,
  input  logic              b_rise,
  input  logic              b_fall,
  input  logic              fs_lvl,
  input  logic              fs_rise,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic              pcm,
  output logic              oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  tx_state_e         state;
  logic [CNT_W-1:0]  nbits;
  logic [DATA_W-1:0] hold, shreg;
  logic              hold_full, accept, start;

  assign s_tready = !hold_full;
  assign accept   = s_tvalid && s_tready;
  assign start    = (state == TX_ARMED && b_rise) ||
                    (state == TX_IDLE && long_mode && fs_rise && b_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      shreg     <= '0;
    end else begin
      if (accept) hold <= s_tdata;
      if (start) begin
        shreg     <= hold;
        hold_full <= accept;
      end else begin
        hold_full <= hold_full | accept;
        if (state == TX_SHIFT && b_rise && nbits != LAST)
          shreg <= {shreg[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      nbits <= '0;
      oe    <= 1'b0;
    end else if (start) begin
      state <= TX_SHIFT;
      nbits <= CNT_W'(1);
      oe    <= 1'b1;
    end else begin
      unique case (state)
        TX_IDLE: begin
          if (long_mode && fs_rise) state <= TX_ARMED;
          else if (!long_mode && b_fall && fs_lvl) state <= TX_ARMED;
        end
        TX_ARMED: ;
        TX_SHIFT: begin
          if (b_rise && nbits != LAST) nbits <= nbits + 1'b1;
          else if (b_fall && nbits == LAST) begin
            if (long_mode && fs_lvl) state <= TX_DRAIN;
            else begin
              state <= TX_IDLE;
              oe    <= 1'b0;
            end
          end
        end
        TX_DRAIN: begin
          if (!fs_lvl) begin
            state <= TX_IDLE;
            oe    <= 1'b0;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign pcm = shreg[DATA_W-1];

  a_r10_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && !start |=> $stable(hold));
  a_r3_shift_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe) && !$stable(shreg) |-> $past(b_rise));
  a_r5_close_after_fs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) && $past(long_mode) |-> !$past(fs_lvl));
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_mode,
  input  logic              b_fall,
  input  logic              fs_lvl,
  input  logic              fs_rise,
  input  logic              data_lvl,
  input  logic              len_done,
  input  logic [LEN_W-1:0]  len_cnt,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_half_lsb
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              busy, half_lat, trig;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sreg;

  assign trig = !busy && (long_mode ? fs_rise : (b_fall && fs_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      sreg       <= '0;
      half_lat   <= 1'b0;
      m_tdata    <= '0;
      m_tvalid   <= 1'b0;
      m_half_lsb <= 1'b0;
    end else begin
      m_tvalid <= 1'b0;
      if (fs_rise) half_lat <= 1'b0;
      else if (len_done) half_lat <= (len_cnt == LEN_W'(2));
      if (trig) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy && b_fall) begin
        sreg <= {sreg[DATA_W-2:0], data_lvl};
        cnt  <= cnt + 1'b1;
        if (cnt == CNT_W'(DATA_W - 1)) begin
          busy       <= 1'b0;
          m_tdata    <= {sreg[DATA_W-2:0], data_lvl};
          m_tvalid   <= 1'b1;
          m_half_lsb <= half_lat;
        end
      end
    end
  end

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |=> !m_tvalid);
  a_r6_valid_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !busy && $past(busy));
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int DATA_W   = 8,
  parameter int STAGES   = 2,
  parameter int LONG_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_bclk,
  input  logic              tx_fsync,
  input  logic              rx_bclk,
  input  logic              rx_fsync,
  input  logic              rx_pcm,
  output logic              tx_pcm,
  output logic              tx_pcm_oe,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_half_lsb,
  output logic              long_mode
);
  localparam int LEN_W = $clog2(LONG_MIN + 1);

  logic [1:0] txl, txr, txf;
  logic [2:0] rxl, rxr, rxf;
  logic             tx_len_done, rx_len_done;
  logic [LEN_W-1:0] tx_len, rx_len;

  pcm_sync_edge #(.W(2), .STAGES(STAGES)) u_tx_sync (
    .clk(clk), .rst_n(rst_n), .din({tx_fsync, tx_bclk}),
    .lvl(txl), .rise(txr), .fall(txf));

  pcm_sync_edge #(.W(3), .STAGES(STAGES)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .din({rx_pcm, rx_fsync, rx_bclk}),
    .lvl(rxl), .rise(rxr), .fall(rxf));

  pcm_fs_len #(.LEN_W(LEN_W)) u_tx_len (
    .clk(clk), .rst_n(rst_n), .fs_lvl(txl[1]), .fs_rise(txr[1]),
    .fs_fall(txf[1]), .b_fall(txf[0]), .len_done(tx_len_done), .len_cnt(tx_len));

  pcm_fs_len #(.LEN_W(LEN_W)) u_rx_len (
    .clk(clk), .rst_n(rst_n), .fs_lvl(rxl[1]), .fs_rise(rxr[1]),
    .fs_fall(rxf[1]), .b_fall(rxf[0]), .len_done(rx_len_done), .len_cnt(rx_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) long_mode <= 1'b0;
    else if (tx_len_done) begin
      if (tx_len == LEN_W'(1)) long_mode <= 1'b0;
      else if (tx_len >= LEN_W'(LONG_MIN)) long_mode <= 1'b1;
    end
  end

  pcm_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .b_lvl(txl[0]), .b_rise(txr[0]), .b_fall(txf[0]),
    .fs_lvl(txl[1]), .fs_rise(txr[1]),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .pcm(tx_pcm), .oe(tx_pcm_oe));

  pcm_rx #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .b_fall(rxf[0]), .fs_lvl(rxl[1]), .fs_rise(rxr[1]), .data_lvl(rxl[2]),
    .len_done(rx_len_done), .len_cnt(rx_len),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_half_lsb(m_half_lsb));

  a_r2_mode_on_fs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(long_mode) |-> $past(tx_len_done));
endmodule

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, rxd = 1'b0;
  logic [7:0] s_tdata = '0;
  logic s_tvalid = 1'b0;
  logic tx_pcm, tx_pcm_oe, s_tready, m_tvalid, m_half_lsb, long_mode;
  logic [7:0] m_tdata;

  int checks = 0, errors = 0, rx_cnt = 0;
  logic [7:0] got_byte = '0;
  logic got_half = 1'b0;
  bit mlong = 1'b0, full_m = 1'b0, done = 1'b0;
  logic [7:0] hold_m = '0;

  always #5 clk = ~clk;

  pcm_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .tx_bclk(bclk), .tx_fsync(fsync),
    .rx_bclk(bclk), .rx_fsync(fsync), .rx_pcm(rxd),
    .tx_pcm(tx_pcm), .tx_pcm_oe(tx_pcm_oe),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_half_lsb(m_half_lsb),
    .long_mode(long_mode));

  always @(posedge clk) if (m_tvalid) begin
    got_byte <= m_tdata;
    got_half <= m_half_lsb;
    rx_cnt   <= rx_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_oe(input int p, input bit rphase, input int s,
                                input bit lng, input int fs_len);
    if (p < s) return 1'b0;
    if (lng && p < fs_len) return 1'b1;
    return rphase ? (p <= s + 7) : (p < s + 7);
  endfunction

  function automatic bit next_mode(input bit cur, input int fs_len);
    if (fs_len == 1) return 1'b0;
    if (fs_len >= 3) return 1'b1;
    return cur;
  endfunction

  task automatic push(input logic [7:0] b);
    if (full_m) begin
      chk("R10 ready low while full", s_tready, 0);
      s_tvalid = 1'b1; s_tdata = b;
      tick(2);
      s_tvalid = 1'b0;
    end else begin
      chk("R10 ready when empty", s_tready, 1);
      s_tvalid = 1'b1; s_tdata = b;
      tick(1);
      s_tvalid = 1'b0;
      hold_m = b; full_m = 1'b1;
      chk("R10 ready drops after accept", s_tready, 0);
    end
  endtask

  task automatic run_frame(input int fs_len, input bit early, input logic [7:0] rxb,
                           input bit load_mid, input logic [7:0] midb);
    int s, n, rc0;
    logic [7:0] txexp;
    bit lng;
    lng = mlong;
    s = lng ? 0 : 1;
    n = ((fs_len > s + 8) ? fs_len : s + 8) + 2;
    txexp = hold_m; full_m = 1'b0;
    rc0 = rx_cnt;
    if (early) begin
      bclk = 1'b0; fsync = 1'b1;
      tick(4);
      chk("R4 waits for bit clock rise", tx_pcm_oe, 0);
      tick(4);
    end
    for (int p = 0; p < n; p++) begin
      int k;
      k = p - s;
      bclk = 1'b1; fsync = (p < fs_len);
      rxd = (k >= 0 && k < 8) ? rxb[7-k] : 1'b0;
      tick(5);
      chk(lng ? "R4 R5 oe at rise" : "R3 oe at rise", tx_pcm_oe, exp_oe(p, 1, s, lng, fs_len));
      if (k >= 0 && k < 8)
        chk(lng ? "R4 tx bit" : "R3 tx bit", tx_pcm, txexp[7-k]);
      if (load_mid && p == 3) begin
        s_tvalid = 1'b1; s_tdata = midb;
        tick(1);
        s_tvalid = 1'b0;
        hold_m = midb; full_m = 1'b1;
        tick(2);
      end else tick(3);
      bclk = 1'b0;
      tick(5);
      chk(lng ? "R5 oe at fall" : "R3 oe at fall", tx_pcm_oe, exp_oe(p, 0, s, lng, fs_len));
      tick(3);
    end
    fsync = 1'b0; rxd = 1'b0;
    tick(32);
    chk("R9 one strobe per frame", rx_cnt - rc0, 1);
    chk(lng ? "R7 rx byte" : "R6 rx byte", got_byte, rxb);
    chk("R8 half lsb flag", got_half, fs_len == 2);
    mlong = next_mode(mlong, fs_len);
    chk("R2 mode after frame", long_mode, mlong);
  endtask

  initial begin
    int r;
    r = $urandom(32'd4711);
    tick(3);
    chk("R1 reset oe", tx_pcm_oe, 0);
    chk("R1 reset mode", long_mode, 0);
    chk("R1 reset ready", s_tready, 1);
    chk("R1 reset valid", m_tvalid, 0);
    rst_n = 1'b1;
    tick(4);
    push(8'hA5); run_frame(1, 0, 8'h3C, 0, 0);
    push(8'h81); run_frame(2, 0, 8'hC3, 0, 0);
    push(8'h5A); run_frame(4, 0, 8'h0F, 0, 0);
    push(8'hE7); run_frame(3, 0, 8'h96, 1, 8'h24);
    run_frame(4, 1, 8'h71, 0, 0);
    push(8'hFE); run_frame(10, 0, 8'h01, 0, 0);
    push(8'h13); run_frame(2, 0, 8'hEE, 0, 0);
    push(8'h7F); push(8'h00);
    run_frame(1, 0, 8'h80, 0, 0);
    run_frame(1, 0, 8'h55, 0, 0);
    for (int i = 0; i < 24; i++) begin
      int fl;
      logic [7:0] tb, rb;
      fl = 1 + int'($urandom % 6);
      tb = 8'($urandom); rb = 8'($urandom);
      if (($urandom % 4) != 0) push(tb);
      run_frame(fl, 0, rb, 0, 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule